// File: doc/BRIEF.md
# Tile Pixel Fetcher

This block turns one 16-bit tile descriptor into the 64 coloured pixels of an 8x8 tile with four bits per pixel. The descriptor carries an 11-bit tile number, two mirror bits and a 2-bit palette selector. The block reads the tile's bytes from video RAM through a byte read port. For each pixel it picks the correct nibble and looks up its colour in a 128-byte palette RAM, where each colour is a big-endian 16-bit word. It then presents the colour as 24-bit RGB on a valid/ready pixel stream.

A pulse on `start` with a descriptor captures that descriptor. Pixels leave in row-major order, eight per row, under consumer back-pressure. After the 64th accepted pixel, `done` pulses for one cycle and the block returns to idle. Both memories answer a read one clock cycle after the request.

Top module: `tile_pixel_fetch`

## Requirements
- R1: After reset, `pix_valid`, `done`, `busy`, `vram_rd_en` and `pal_rd_en` are all 0.
- R2: Descriptor bits 10:0 are the tile number. Each pixel's video RAM byte address is tile*32 + row*4 + bytecol, where bytecol is the pixel's column divided by 2 and row/bytecol are the values after mirroring.
- R3: With no mirroring, pixels come out row-major from the top-left corner, and the high nibble of each byte is the left pixel of its pair.
- R4: Descriptor bit 11 set mirrors horizontally: byte columns are read 3 down to 0, and the low nibble of each byte comes out first.
- R5: Descriptor bit 12 set mirrors vertically: rows are read 7 down to 0.
- R6: For a non-zero colour index c and palette p (descriptor bits 14:13), the palette RAM is read at byte {p,c,0} (upper half of the word) and then, in the next cycle, at {p,c,1} (lower half).
- R7: The palette word w maps to RGB as follows: bits 23:20 = w[3:0], bits 15:12 = w[7:4], bits 7:4 = w[11:8], and all other RGB bits are 0.
- R8: A colour index of 0 gives `pix_transparent`=1 and `pix_rgb`=0 whatever the palette, and no palette read is issued for that pixel.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_rgb` and `pix_transparent` hold. A pixel is consumed only on a cycle with both `pix_valid` and `pix_ready` high.
- R10: Exactly 64 pixels are delivered per descriptor. `done` is high for one cycle, in the cycle after the 64th handshake, and `busy` is low in the cycle after that.
- R11: A `start` pulse while `busy` is high is ignored, and the tile in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tile when idle |
| name_in | input | 16 | Tile descriptor (tile, mirrors, palette) |
| busy | output | 1 | A tile is in progress |
| done | output | 1 | One-cycle pulse after the final pixel |
| pix_valid | output | 1 | Pixel stream valid |
| pix_ready | input | 1 | Pixel stream ready |
| pix_rgb | output | 24 | Pixel colour |
| pix_transparent | output | 1 | Pixel has colour index 0 |
| vram_rd_en | output | 1 | Video RAM read request |
| vram_rd_addr | output | 16 | Video RAM byte address |
| vram_rd_data | input | 8 | Video RAM data, one cycle after request |
| pal_rd_en | output | 1 | Palette RAM read request |
| pal_rd_addr | output | 7 | Palette RAM byte address |
| pal_rd_data | input | 8 | Palette RAM data, one cycle after request |

## Verification
Descriptors cover every mirror combination, several palettes and tile numbers near both ends of the index range. Each pixel is compared against a bench model of the byte/nibble selection and the colour expansion, so a swapped nibble, a wrong row or column order and a misplaced colour channel each produce distinct mismatches. Half the descriptors are fed with a stalling consumer to separate hold-under-back-pressure from free-flowing delivery. An all-zero tile isolates the transparent path and the absence of palette reads, and a start pulse in mid-tile shows that the captured descriptor is kept.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  localparam int ROW_BITS   = 3;
  localparam int COL_BITS   = 3;
  localparam int PIX_BITS   = ROW_BITS + COL_BITS;
  localparam int IDX_W      = 11;
  localparam int NIB_W      = 4;
  localparam int BYTE_W     = 8;
  localparam int PAL_SEL_W  = 2;
  localparam int BIT_HMIR   = 11;
  localparam int BIT_VMIR   = 12;
  localparam int BIT_PAL_LO = 13;

  typedef enum logic [2:0] {
    ST_IDLE, ST_VREQ, ST_VDAT, ST_PHI, ST_PLO, ST_OUT, ST_DONE
  } tpf_state_t;
endpackage

// File: rtl/tpf_addr_gen.sv
module tpf_addr_gen
  import tpf_pkg::*;
#(
  parameter int NAME_W  = 16,
  parameter int VRAM_AW = 16
) (
  input  logic [NAME_W-1:0]   name,
  input  logic [PIX_BITS-1:0] pix,
  output logic [VRAM_AW-1:0]  vram_addr,
  output logic                take_high
);
  localparam int BC_W  = COL_BITS - 1;
  localparam int RAW_W = IDX_W + ROW_BITS + BC_W;

  logic [ROW_BITS-1:0] row, erow;
  logic [COL_BITS-1:0] col;
  logic [BC_W-1:0]     ebc;
  logic                hmir, vmir;
  logic [RAW_W-1:0]    raw;

  always_comb begin
    row       = pix[PIX_BITS-1:COL_BITS];
    col       = pix[COL_BITS-1:0];
    hmir      = name[BIT_HMIR];
    vmir      = name[BIT_VMIR];
    erow      = vmir ? ~row : row;
    ebc       = hmir ? ~col[COL_BITS-1:1] : col[COL_BITS-1:1];
    raw       = {name[IDX_W-1:0], erow, ebc};
    vram_addr = VRAM_AW'(raw);
    take_high = ~(col[0] ^ hmir);
  end
endmodule

// File: rtl/tpf_color_expand.sv
module tpf_color_expand
  import tpf_pkg::*;
#(
  parameter int CHANNELS = 3,
  parameter int WORD_W   = 16
) (
  input  logic [WORD_W-1:0]          pal_word,
  output logic [CHANNELS*BYTE_W-1:0] rgb
);
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    assign rgb[ch*BYTE_W +: BYTE_W] =
      {pal_word[(CHANNELS-1-ch)*NIB_W +: NIB_W], {(BYTE_W-NIB_W){1'b0}}};
  end
endmodule

// File: rtl/tpf_seq.sv
module tpf_seq
  import tpf_pkg::*;
#(
  parameter int NAME_W = 16,
  parameter int PAL_AW = 7,
  parameter int RGB_W  = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [NAME_W-1:0]   name_in,
  input  logic                pix_ready,
  input  logic                take_high,
  input  logic [BYTE_W-1:0]   vram_rd_data,
  input  logic [BYTE_W-1:0]   pal_rd_data,
  input  logic [RGB_W-1:0]    rgb_in,
  output logic [NAME_W-1:0]   cur_name,
  output logic [PIX_BITS-1:0] cur_pix,
  output logic                vram_rd_en,
  output logic                pal_rd_en,
  output logic [PAL_AW-1:0]   pal_rd_addr,
  output logic [2*BYTE_W-1:0] pal_word,
  output logic                pix_valid,
  output logic [RGB_W-1:0]    pix_rgb,
  output logic                pix_transparent,
  output logic                done,
  output logic                busy
);
  localparam logic [PIX_BITS-1:0] LAST_PIX = '1;

  tpf_state_t          state;
  logic [NAME_W-1:0]   name_q;
  logic [PIX_BITS-1:0] pix_q;
  logic [NIB_W-1:0]    colour_q, colour_now;
  logic [BYTE_W-1:0]   hi_q;
  logic [PAL_SEL_W-1:0] pal_sel;

  assign cur_name  = name_q;
  assign cur_pix   = pix_q;
  assign pix_valid = (state == ST_OUT);
  assign done      = (state == ST_DONE);
  assign busy      = (state != ST_IDLE);
  assign pal_sel   = name_q[BIT_PAL_LO +: PAL_SEL_W];
  assign pal_word  = {hi_q, pal_rd_data};

  always_comb begin
    colour_now  = take_high ? vram_rd_data[BYTE_W-1:NIB_W] : vram_rd_data[NIB_W-1:0];
    vram_rd_en  = (state == ST_VREQ);
    pal_rd_en   = 1'b0;
    pal_rd_addr = '0;
    if (state == ST_VDAT && colour_now != '0) begin
      pal_rd_en   = 1'b1;
      pal_rd_addr = PAL_AW'({pal_sel, colour_now, 1'b0});
    end else if (state == ST_PHI) begin
      pal_rd_en   = 1'b1;
      pal_rd_addr = PAL_AW'({pal_sel, colour_q, 1'b1});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= ST_IDLE;
      name_q          <= '0;
      pix_q           <= '0;
      colour_q        <= '0;
      hi_q            <= '0;
      pix_rgb         <= '0;
      pix_transparent <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          name_q <= name_in;
          pix_q  <= '0;
          state  <= ST_VREQ;
        end
        ST_VREQ: state <= ST_VDAT;
        ST_VDAT: begin
          if (colour_now == '0) begin
            pix_transparent <= 1'b1;
            pix_rgb         <= '0;
            state           <= ST_OUT;
          end else begin
            colour_q <= colour_now;
            state    <= ST_PHI;
          end
        end
        ST_PHI: begin
          hi_q  <= pal_rd_data;
          state <= ST_PLO;
        end
        ST_PLO: begin
          pix_rgb         <= rgb_in;
          pix_transparent <= 1'b0;
          state           <= ST_OUT;
        end
        ST_OUT: if (pix_ready) begin
          if (pix_q == LAST_PIX) state <= ST_DONE;
          else begin
            pix_q <= pix_q + 1'b1;
            state <= ST_VREQ;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_rgb) && $stable(pix_transparent)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_transp_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_transparent) |-> (pix_rgb == '0));

  assert_rd_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vram_rd_en, pal_rd_en}));

  assert_pal_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_rd_en && !pal_rd_addr[0]) |=> (pal_rd_en && pal_rd_addr[0]));

  assert_name_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(cur_name));
endmodule

// File: rtl/tile_pixel_fetch.sv
module tile_pixel_fetch
  import tpf_pkg::*;
#(
  parameter int NAME_W  = 16,
  parameter int VRAM_AW = 16,
  parameter int PAL_AW  = 7,
  parameter int RGB_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [NAME_W-1:0]  name_in,
  output logic               busy,
  output logic               done,
  output logic               pix_valid,
  input  logic               pix_ready,
  output logic [RGB_W-1:0]   pix_rgb,
  output logic               pix_transparent,
  output logic               vram_rd_en,
  output logic [VRAM_AW-1:0] vram_rd_addr,
  input  logic [BYTE_W-1:0]  vram_rd_data,
  output logic               pal_rd_en,
  output logic [PAL_AW-1:0]  pal_rd_addr,
  input  logic [BYTE_W-1:0]  pal_rd_data
);
  localparam int CHANNELS = RGB_W / BYTE_W;
  localparam int WORD_W   = 2 * BYTE_W;

  logic [NAME_W-1:0]   cur_name;
  logic [PIX_BITS-1:0] cur_pix;
  logic                take_high;
  logic [WORD_W-1:0]   pal_word;
  logic [RGB_W-1:0]    rgb_exp;

  tpf_addr_gen #(.NAME_W(NAME_W), .VRAM_AW(VRAM_AW)) u_addr (
    .name      (cur_name),
    .pix       (cur_pix),
    .vram_addr (vram_rd_addr),
    .take_high (take_high)
  );

  tpf_color_expand #(.CHANNELS(CHANNELS), .WORD_W(WORD_W)) u_expand (
    .pal_word (pal_word),
    .rgb      (rgb_exp)
  );

  tpf_seq #(.NAME_W(NAME_W), .PAL_AW(PAL_AW), .RGB_W(RGB_W)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .start           (start),
    .name_in         (name_in),
    .pix_ready       (pix_ready),
    .take_high       (take_high),
    .vram_rd_data    (vram_rd_data),
    .pal_rd_data     (pal_rd_data),
    .rgb_in          (rgb_exp),
    .cur_name        (cur_name),
    .cur_pix         (cur_pix),
    .vram_rd_en      (vram_rd_en),
    .pal_rd_en       (pal_rd_en),
    .pal_rd_addr     (pal_rd_addr),
    .pal_word        (pal_word),
    .pix_valid       (pix_valid),
    .pix_rgb         (pix_rgb),
    .pix_transparent (pix_transparent),
    .done            (done),
    .busy            (busy)
  );

  assert_vram_in_tile_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vram_rd_en |-> (vram_rd_addr[VRAM_AW-1:5] == VRAM_AW'(cur_name[IDX_W-1:0])));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pix_valid && !vram_rd_en && !pal_rd_en));
endmodule

// File: tb/sim_tile_pixel_fetch.sv
`timescale 1ns/1ps
module sim_tile_pixel_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] name_in = '0;
  logic        busy, done, pix_valid, pix_transparent;
  logic        pix_ready = 1'b0;
  logic [23:0] pix_rgb;
  logic        vram_rd_en, pal_rd_en;
  logic [15:0] vram_rd_addr;
  logic [6:0]  pal_rd_addr;
  logic [7:0]  vram_rd_data, pal_rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int pal_reads = 0;

  always #10 clk = ~clk;

  tile_pixel_fetch u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .name_in(name_in),
    .busy(busy), .done(done), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_rgb(pix_rgb), .pix_transparent(pix_transparent),
    .vram_rd_en(vram_rd_en), .vram_rd_addr(vram_rd_addr), .vram_rd_data(vram_rd_data),
    .pal_rd_en(pal_rd_en), .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data)
  );

  function automatic logic [7:0] vram_f(logic [15:0] a);
    logic [7:0] v;
    if (a[15:5] == 11'h7FF) return 8'h00;
    v = a[7:0] * 8'd29 + a[15:8];
    return v ^ 8'h3C;
  endfunction

  function automatic logic [7:0] pal_f(logic [6:0] a);
    return {a, 1'b1} ^ 8'h5A;
  endfunction

  always_ff @(posedge clk) begin
    if (vram_rd_en) vram_rd_data <= vram_f(vram_rd_addr);
    if (pal_rd_en) pal_rd_data <= pal_f(pal_rd_addr);
  end

  always @(posedge clk) if (pal_rd_en) pal_reads++;

  function automatic logic [15:0] exp_addr(logic [15:0] nm, int p);
    int row, col, r, bc;
    row = p / 8; col = p % 8;
    r  = nm[12] ? 7 - row : row;
    bc = nm[11] ? 3 - col / 2 : col / 2;
    return 16'(int'(nm[10:0]) * 32 + r * 4 + bc);
  endfunction

  function automatic logic [3:0] exp_colour(logic [15:0] nm, int p);
    logic [7:0] b;
    logic hi;
    b  = vram_f(exp_addr(nm, p));
    hi = nm[11] ? ((p % 2) == 1) : ((p % 2) == 0);
    return hi ? b[7:4] : b[3:0];
  endfunction

  function automatic logic [24:0] exp_pix(logic [15:0] nm, int p);
    logic [3:0]  c;
    logic [6:0]  pa;
    logic [15:0] w;
    c = exp_colour(nm, p);
    if (c == 4'h0) return {1'b1, 24'h0};
    pa = {nm[14:13], c, 1'b0};
    w  = {pal_f(pa), pal_f(pa | 7'h1)};
    return {1'b0, w[3:0], 4'h0, w[7:4], 4'h0, w[11:8], 4'h0};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_tile(input logic [15:0] nm, input bit stall, input bit poke);
    string tag;
    logic [24:0] e;
    logic [23:0] hold_rgb;
    logic hold_tr;
    tag = nm[11] ? "R4" : (nm[12] ? "R5" : "R3");
    @(negedge clk);
    name_in = nm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 64; k++) begin
      while (!vram_rd_en) @(negedge clk);
      check(vram_rd_addr == exp_addr(nm, k), "R2", "vram address",
            32'(vram_rd_addr), 32'(exp_addr(nm, k)));
      @(negedge clk);
      if (exp_colour(nm, k) != 4'h0)
        check(pal_rd_en && pal_rd_addr == {nm[14:13], exp_colour(nm, k), 1'b0}, "R6",
              "palette address", 32'(pal_rd_addr), 32'({nm[14:13], exp_colour(nm, k), 1'b0}));
      while (!pix_valid) @(negedge clk);
      e = exp_pix(nm, k);
      check(pix_rgb == e[23:0], tag, "pixel rgb (R7)", 32'(pix_rgb), 32'(e[23:0]));
      check(pix_transparent == e[24], "R8", "transparent flag", 32'(pix_transparent), 32'(e[24]));
      if (stall) begin
        hold_rgb = pix_rgb; hold_tr = pix_transparent;
        repeat (2) begin
          @(negedge clk);
          check(pix_valid && pix_rgb == hold_rgb && pix_transparent == hold_tr, "R9",
                "hold under stall", 32'(pix_rgb), 32'(hold_rgb));
        end
      end
      pix_ready = 1'b1;
      if (poke && k == 10) begin name_in = 16'h1FFF; start = 1'b1; end
      @(negedge clk);
      pix_ready = 1'b0; start = 1'b0;
      if (k < 63) check(!pix_valid, "R9", "single handshake", 32'(pix_valid), 32'd0);
    end
    check(done == 1'b1, "R10", "done pulse", 32'(done), 32'd1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10", "done width and idle",
          32'({done, busy}), 32'd0);
  endtask

  localparam logic [16:0] VECS [6] = '{
    {1'b0, 16'h0003},
    {1'b1, 16'h0805},
    {1'b0, 16'h1007},
    {1'b1, 16'h7ABC},
    {1'b0, 16'h4123},
    {1'b1, 16'h27FE}
  };

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!pix_valid && !done && !busy && !vram_rd_en && !pal_rd_en, "R1", "reset outputs",
          32'({pix_valid, done, busy, vram_rd_en, pal_rd_en}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !pix_valid, "R1", "idle after reset", 32'({busy, pix_valid}), 32'd0);

    for (int i = 0; i < 6; i++) run_tile(VECS[i][15:0], VECS[i][16], 1'b0);

    pal_reads = 0;
    run_tile(16'h67FF, 1'b0, 1'b0);
    check(pal_reads == 0, "R8", "no palette reads on empty tile", 32'(pal_reads), 32'd0);

    run_tile(16'h0003, 1'b0, 1'b1);
    check(!busy, "R11", "ignored start leaves block idle", 32'(busy), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule